// File: doc/BRIEF.md
# Pipeline Snapshot Test Capture

This block takes diagnostic snapshots of a video pixel pipeline. The capture trigger travels inside the pixel stream itself. Bit 7 of the red input is watched, and a transition of that bit in the chosen direction marks the pixel that is sampled. The 24-bit RGB value of that pixel is stored at once in a pixel snapshot register. The same pixel reaches the downstream DAC stage `DELAY` clocks later. At that point its 30-bit colour value and its sync, blank and intensity flags are stored in a second register set.

A host reads every snapshot one byte at a time through an 8-bit register port. It picks a register with a select code, writes that code to rewind the register's byte pointer, and pulses a read strobe to step through the bytes. Snapshots stay unchanged until the next valid trigger, which replaces them whether or not they were read. This lets a continuously clocked display be probed by embedding marker pixels in the frame.

Top module: `pipe_snapshot`

## Requirements
- R1: A capture trigger occurs only when red bit 7 differs from its value on the previous clock. The stored previous value resets to 0.
- R2: With `trig_fall_i`=0, only a 0-to-1 transition of red bit 7 triggers. With `trig_fall_i`=1, only a 1-to-0 transition triggers.
- R3: On a trigger, the triggering pixel's red, green and blue bytes are stored in the pixel snapshot at the same clock edge. After reset the snapshot reads all zeros.
- R4: The DAC-stage inputs are stored exactly `DELAY` clocks after the trigger, together with a status byte. The status byte holds sync in bit 0, blank in bit 1, intensity in bit 2, and zeros in bits 7..3.
- R5: When `wide_mode_i`=0 at the DAC-stage capture, bits 9..8 of each stored colour are zero.
- R6: When `blank_i`=0 at the DAC-stage capture, all three stored colours are zero. The status byte is still stored.
- R7: Snapshots hold while no trigger occurs. A later trigger overwrites them whether or not they were read, even when it falls in the same cycle as the delayed capture of an earlier trigger.
- R8: `reg_sel_i` codes: 0 = pixel snapshot, 1 = DAC snapshot, 2 = status byte, 3 = reads 0x00. `rd_data_o` shows the selected byte combinationally.
- R9: The pixel snapshot reads red, green, blue on successive strobes, then wraps to red.
- R10: In wide mode the DAC snapshot reads red low, red high, green low, green high, blue low, blue high, then wraps. Each high byte is bits 9..8 zero-extended. In narrow mode it reads red low, green low, blue low, then wraps.
- R11: Pulsing `sel_wr_i` rewinds the selected register's pointer to its first byte, and this wins over a strobe in the same cycle. A strobe advances only the selected register's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| red_i | input | 8 | Red of the incoming pixel; bit 7 carries the trigger |
| green_i | input | 8 | Green of the incoming pixel |
| blue_i | input | 8 | Blue of the incoming pixel |
| trig_fall_i | input | 1 | 0: rising trigger, 1: falling trigger |
| dac_red_i | input | 10 | Red at the DAC stage |
| dac_green_i | input | 10 | Green at the DAC stage |
| dac_blue_i | input | 10 | Blue at the DAC stage |
| sync_i | input | 1 | Sync flag at the DAC stage |
| blank_i | input | 1 | Blank flag at the DAC stage, low blanks |
| intens_i | input | 1 | Intensity flag at the DAC stage |
| wide_mode_i | input | 1 | 1: 10-bit colours, 0: 8-bit colours |
| reg_sel_i | input | 2 | Register select code |
| sel_wr_i | input | 1 | Rewind the selected register's byte pointer |
| rd_stb_i | input | 1 | Read strobe, advances the selected pointer |
| rd_data_o | output | 8 | Selected snapshot byte |

## Verification
The pixel capture of a new trigger and the delayed DAC-stage capture of an earlier trigger can happen on the same clock edge. To provoke this, the bench places two trigger edges exactly `DELAY` pixels apart. In the cycle right after that edge it switches the select code combinationally. It expects the pixel snapshot to show the second marker pixel and the DAC snapshot to show the first. After a further flush, the DAC snapshot must have moved on to the second marker.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int PIX_W  = 8;
  localparam int DAC_W  = 10;
  localparam int BYTE_W = 8;
  localparam int STAT_W = 3;

  typedef enum logic [1:0] {
    SEL_PIX  = 2'd0,
    SEL_DAC  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PIX_W-1:0] r;
    logic [PIX_W-1:0] g;
    logic [PIX_W-1:0] b;
  } pix_t;

  typedef struct packed {
    logic [DAC_W-1:0] r;
    logic [DAC_W-1:0] g;
    logic [DAC_W-1:0] b;
  } dac_t;
endpackage

// File: rtl/snap_trig.sv
module snap_trig #(
  parameter int DELAY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mark_i,
  input  logic fall_i,
  output logic trig_o,
  output logic late_o
);
  logic             prev_q;
  logic [DELAY-1:0] pipe_q;

  assign trig_o = fall_i ? (prev_q & ~mark_i) : (~prev_q & mark_i);
  assign late_o = pipe_q[DELAY-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= mark_i;
  end

  // trigger travels alongside the pixel to the DAC stage
  generate
    if (DELAY == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= trig_o;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[DELAY-2:0], trig_o};
      end
    end
  endgenerate

  // R2
  trig_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (mark_i == !fall_i));

  // R1
  trig_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o || (fall_i != $past(fall_i)));
endmodule

// File: rtl/snap_rdport.sv
module snap_rdport
  import snap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              wide_i,
  input  pix_t              pix_i,
  input  dac_t              dac_i,
  input  logic [BYTE_W-1:0] stat_i,
  output logic [BYTE_W-1:0] data_o
);
  localparam int PIX_LAST  = 2;
  localparam int DAC_WLAST = 5;
  localparam int DAC_NLAST = 2;
  localparam int PAD_W     = 2 * BYTE_W - DAC_W;

  logic [1:0]       pix_ptr_q;
  logic [2:0]       dac_ptr_q;
  logic [2:0]       dac_last;
  logic [DAC_W-1:0] col_sel;

  assign dac_last = wide_i ? 3'(DAC_WLAST) : 3'(DAC_NLAST);

  function automatic logic [DAC_W-1:0] pick(dac_t d, logic [1:0] idx);
    case (idx)
      2'd0:    return d.r;
      2'd1:    return d.g;
      default: return d.b;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_ptr_q <= '0;
      dac_ptr_q <= '0;
    end else if (wr_i) begin
      if (sel_i == SEL_PIX) pix_ptr_q <= '0;
      if (sel_i == SEL_DAC) dac_ptr_q <= '0;
    end else if (rd_i) begin
      if (sel_i == SEL_PIX)
        pix_ptr_q <= (pix_ptr_q >= 2'(PIX_LAST)) ? 2'd0 : pix_ptr_q + 2'd1;
      if (sel_i == SEL_DAC)
        dac_ptr_q <= (dac_ptr_q >= dac_last) ? 3'd0 : dac_ptr_q + 3'd1;
    end
  end

  always_comb begin
    data_o  = '0;
    col_sel = wide_i ? pick(dac_i, dac_ptr_q[2:1]) : pick(dac_i, dac_ptr_q[1:0]);
    case (sel_i)
      SEL_PIX: begin
        case (pix_ptr_q)
          2'd0:    data_o = pix_i.r;
          2'd1:    data_o = pix_i.g;
          default: data_o = pix_i.b;
        endcase
      end
      SEL_DAC: begin
        if (wide_i && dac_ptr_q[0]) data_o = {{PAD_W{1'b0}}, col_sel[DAC_W-1:BYTE_W]};
        else                        data_o = col_sel[BYTE_W-1:0];
      end
      SEL_STAT: data_o = stat_i;
      default:  data_o = '0;
    endcase
  end

  // R9
  pix_ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ptr_q <= 2'(PIX_LAST));

  // R10
  dac_ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_ptr_q <= 3'(DAC_WLAST));

  // R11
  ptr_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_DAC) |=> (dac_ptr_q == '0));
endmodule

// File: rtl/pipe_snapshot.sv
module pipe_snapshot
  import snap_pkg::*;
#(
  parameter int DELAY = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  red_i,
  input  logic [PIX_W-1:0]  green_i,
  input  logic [PIX_W-1:0]  blue_i,
  input  logic              trig_fall_i,
  input  logic [DAC_W-1:0]  dac_red_i,
  input  logic [DAC_W-1:0]  dac_green_i,
  input  logic [DAC_W-1:0]  dac_blue_i,
  input  logic              sync_i,
  input  logic              blank_i,
  input  logic              intens_i,
  input  logic              wide_mode_i,
  input  logic [1:0]        reg_sel_i,
  input  logic              sel_wr_i,
  input  logic              rd_stb_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int STAT_PAD = BYTE_W - STAT_W;
  localparam int TOP_W    = DAC_W - BYTE_W;

  logic              trig, late;
  pix_t              pix_q;
  dac_t              dac_q, dac_in;
  logic [BYTE_W-1:0] stat_q;

  function automatic logic [DAC_W-1:0] narrow(logic [DAC_W-1:0] c, logic wide);
    return wide ? c : {{TOP_W{1'b0}}, c[BYTE_W-1:0]};
  endfunction

  assign dac_in.r = narrow(dac_red_i,   wide_mode_i);
  assign dac_in.g = narrow(dac_green_i, wide_mode_i);
  assign dac_in.b = narrow(dac_blue_i,  wide_mode_i);

  snap_trig #(.DELAY(DELAY)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mark_i (red_i[PIX_W-1]),
    .fall_i (trig_fall_i),
    .trig_o (trig),
    .late_o (late)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q  <= '0;
      dac_q  <= '0;
      stat_q <= '0;
    end else begin
      if (trig) pix_q <= '{r: red_i, g: green_i, b: blue_i};
      if (late) begin
        dac_q  <= blank_i ? dac_in : '0;
        stat_q <= {{STAT_PAD{1'b0}}, intens_i, blank_i, sync_i};
      end
    end
  end

  snap_rdport u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (reg_sel_i),
    .wr_i   (sel_wr_i),
    .rd_i   (rd_stb_i),
    .wide_i (wide_mode_i),
    .pix_i  (pix_q),
    .dac_i  (dac_q),
    .stat_i (stat_q),
    .data_o (rd_data_o)
  );

  // R7
  pix_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig |=> $stable(pix_q));

  // R6
  blank_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_q[1] |-> (dac_q == '0));

  // R4
  stat_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q[BYTE_W-1:STAT_W] == '0);

  // R5
  narrow_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late && !wide_mode_i) |=> (dac_q.r[DAC_W-1:BYTE_W] == '0 &&
                                dac_q.g[DAC_W-1:BYTE_W] == '0 &&
                                dac_q.b[DAC_W-1:BYTE_W] == '0));
endmodule

// File: tb/sim_pipe_snapshot.sv
module sim_pipe_snapshot;
  localparam int DLY = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] red = '0, green = '0, blue = '0;
  logic       st_sync = 1'b0, st_blank = 1'b1, st_int = 1'b0;
  logic       fall = 1'b0, wide = 1'b1;
  logic [1:0] sel = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [9:0] dac_r, dac_g, dac_b;
  logic       d_sync, d_blank, d_int;
  logic [7:0] data;
  logic [32:0] hist [DLY];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  function automatic logic [9:0] d10(logic [7:0] x);
    return {~x[1:0], x};
  endfunction

  // external pipeline model: pixel at cycle k appears at DAC stage in cycle k+DLY
  always @(posedge clk) begin
    hist[0] <= {st_sync, st_blank, st_int, d10(red), d10(green), d10(blue)};
    for (int k = 1; k < DLY; k++) hist[k] <= hist[k-1];
  end
  assign {d_sync, d_blank, d_int, dac_r, dac_g, dac_b} = hist[DLY-1];

  pipe_snapshot #(.DELAY(DLY)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .red_i(red), .green_i(green), .blue_i(blue), .trig_fall_i(fall),
    .dac_red_i(dac_r), .dac_green_i(dac_g), .dac_blue_i(dac_b),
    .sync_i(d_sync), .blank_i(d_blank), .intens_i(d_int),
    .wide_mode_i(wide), .reg_sel_i(sel), .sel_wr_i(wr), .rd_stb_i(rd),
    .rd_data_o(data)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string msg);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                      input logic s, input logic bl, input logic i);
    @(negedge clk);
    red = r; green = g; blue = b; st_sync = s; st_blank = bl; st_int = i;
  endtask

  task automatic flush(input logic [7:0] r);
    for (int k = 0; k < DLY + 2; k++) step(r, 8'(k * 7), 8'(k * 13), 1'b0, 1'b1, 1'b0);
  endtask

  task automatic rewind(input logic [1:0] s);
    @(negedge clk); sel = s; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] s, input logic [7:0] exp, input string msg);
    @(negedge clk); sel = s; rd = 1'b1;
    #1 chk(data, exp, msg);
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic chk_pix(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                         input string msg);
    rewind(2'd0);
    rd_chk(2'd0, r, {msg, " R9 red"});
    rd_chk(2'd0, g, {msg, " R9 green"});
    rd_chk(2'd0, b, {msg, " R9 blue"});
  endtask

  // zero: blanked; top: expected high bytes present
  task automatic chk_dac(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                         input logic zero, input logic top, input string msg);
    logic [9:0] c [3];
    c[0] = zero ? 10'd0 : d10(r);
    c[1] = zero ? 10'd0 : d10(g);
    c[2] = zero ? 10'd0 : d10(b);
    rewind(2'd1);
    for (int k = 0; k < 3; k++) begin
      rd_chk(2'd1, c[k][7:0], {msg, " R10 low"});
      rd_chk(2'd1, top ? {6'd0, c[k][9:8]} : 8'd0, {msg, " R10 high"});
    end
  endtask

  task automatic t_reset;
    chk_pix(8'h00, 8'h00, 8'h00, "R3 reset");
    rd_chk(2'd2, 8'h00, "R8 reset status");
    rd_chk(2'd3, 8'h00, "R8 unused code");
  endtask

  task automatic t_rise;
    fall = 1'b0; wide = 1'b1;
    step(8'h15, 8'h26, 8'h37, 1'b0, 1'b1, 1'b0);
    step(8'h95, 8'h2a, 8'h3b, 1'b1, 1'b1, 1'b0);
    flush(8'h81);
    chk_pix(8'h95, 8'h2a, 8'h3b, "R1 R3 rise");
    rd_chk(2'd0, 8'h95, "R9 wrap");
    chk_dac(8'h95, 8'h2a, 8'h3b, 1'b0, 1'b1, "R4 rise");
    rd_chk(2'd1, 8'h95, "R10 wide wrap");
    rd_chk(2'd2, 8'h03, "R4 status");
  endtask

  task automatic t_fall;
    fall = 1'b1;
    step(8'h81, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    step(8'h42, 8'h53, 8'h64, 1'b0, 1'b1, 1'b1);
    flush(8'h02);
    step(8'hc3, 8'h77, 8'h88, 1'b1, 1'b1, 1'b1);
    flush(8'h83);
    chk_pix(8'h42, 8'h53, 8'h64, "R2 fall");
    chk_dac(8'h42, 8'h53, 8'h64, 1'b0, 1'b1, "R2 fall dac");
    rd_chk(2'd2, 8'h06, "R2 status");
    fall = 1'b0;
  endtask

  task automatic t_narrow;
    wide = 1'b0;
    step(8'h05, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    step(8'ha6, 8'hb7, 8'hc9, 1'b1, 1'b1, 1'b0);
    flush(8'h81);
    rewind(2'd1);
    rd_chk(2'd1, 8'ha6, "R10 narrow red");
    rd_chk(2'd1, 8'hb7, "R10 narrow green");
    rd_chk(2'd1, 8'hc9, "R10 narrow blue");
    rd_chk(2'd1, 8'ha6, "R10 narrow wrap");
    wide = 1'b1;
    chk_dac(8'ha6, 8'hb7, 8'hc9, 1'b0, 1'b0, "R5 masked");
  endtask

  task automatic t_blank;
    step(8'h10, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    step(8'h9d, 8'h31, 8'h42, 1'b1, 1'b0, 1'b1);
    flush(8'h80);
    chk_pix(8'h9d, 8'h31, 8'h42, "R3 blank pixel");
    chk_dac(8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R6 blank");
    rd_chk(2'd2, 8'h05, "R6 status");
  endtask

  task automatic t_hold;
    for (int k = 0; k < 20; k++) step(8'h80 | 8'(k), 8'(k * 3), 8'(k * 5), 1'b1, 1'b1, 1'b1);
    chk_pix(8'h9d, 8'h31, 8'h42, "R7 hold");
    chk_dac(8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R7 hold dac");
    rd_chk(2'd2, 8'h05, "R7 hold status");
  endtask

  task automatic t_overlap;
    rewind(2'd0);
    rewind(2'd1);
    step(8'h20, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    step(8'ha1, 8'h11, 8'h12, 1'b0, 1'b1, 1'b0);
    step(8'h22, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    step(8'h23, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    step(8'h24, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    step(8'hb5, 8'h44, 8'h55, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    sel = 2'd0; #1 chk(data, 8'hb5, "R7 overlap pixel");
    sel = 2'd1; #1 chk(data, 8'ha1, "R4 overlap dac");
    flush(8'hb0);
    chk_dac(8'hb5, 8'h44, 8'h55, 1'b0, 1'b1, "R7 overwrite dac");
  endtask

  task automatic t_ptr;
    rewind(2'd0);
    rd_chk(2'd0, 8'hb5, "R11 first");
    @(negedge clk); sel = 2'd0; rd = 1'b1; wr = 1'b1;
    @(posedge clk); #1 rd = 1'b0; wr = 1'b0;
    rd_chk(2'd0, 8'hb5, "R11 write wins");
    rd_chk(2'd1, 8'hb5, "R11 other reg");
    rd_chk(2'd0, 8'h44, "R11 own pointer");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rise();
    t_fall();
    t_narrow();
    t_blank();
    t_hold();
    t_overlap();
    t_ptr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule